// File: doc/BRIEF.md
# Dual-Edge Up/Down Gain Stepper

This block holds the 6-bit gain code of one amplifier channel. A slow step clock and a direction line drive it. Both lines come from off-chip and are sampled in the system clock domain. A full step pulse is a rising edge followed by a falling edge of the step clock. When the direction line is high through the pulse, the gain goes up. When it is low through the pulse, the gain goes down. A lower code means more gain, so raising the gain makes the code smaller. The code at 63 is the least gain.

If the direction line is at one level at the rising edge and at the other level at the falling edge, the pulse is taken as a reset. A reset puts the code back to the minimum-gain value. Two select pins set how large each step is: 0.5, 1, 2 or 4 dB. These map to code steps of 1, 2, 4 and 8. The code stops at both ends of its range and never wraps. The code output is registered and goes to the interface mode selector that sits downstream.

Top module: `gain_stepper`

## Requirements
- R1: While `rst` is high, and after it is released until the first completed pulse, `gain_code_o` is 63 (all ones).
- R2: A pulse with `step_dat_i` high at both edges lowers `gain_code_o` by the step amount (raising the gain).
- R3: A pulse with `step_dat_i` low at both edges raises `gain_code_o` by the step amount (lowering the gain).
- R4: `step_sel_i` values 0, 1, 2 and 3 give code steps of 1, 2, 4 and 8 (0.5, 1, 2 and 4 dB). The value used is the one present at the falling edge.
- R5: A gain-raising step that would go below 0 leaves the code at 0.
- R6: A gain-lowering step that would go above 63 leaves the code at 63.
- R7: A pulse in which `step_dat_i` differs between the rising and the falling edge sets `gain_code_o` to 63. This holds for either polarity and from any starting code.
- R8: A rising edge of the step clock on its own does not change the code. The code changes only after a falling edge, within four system clock cycles of it reaching the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| step_clk_i | input | 1 | Asynchronous step clock; both edges are used |
| step_dat_i | input | 1 | Asynchronous direction line: high raises gain, low lowers it |
| step_sel_i | input | 2 | Step size select: code steps 1, 2, 4, 8 |
| gain_code_o | output | 6 | Registered gain code; 0 is highest gain, 63 is lowest |

## Verification
The bench runs every step size from the top rail down to 0 and back up to 63, and it steps past each rail. A design that wraps would jump to the opposite end of the range. A design that decodes the select pins wrongly would miss the expected codes partway through the sweep. Reset pulses of both polarities are sent from codes in the middle of the range. A design that looked at only one edge would treat these as ordinary steps and leave the code near where it was. The bench holds the step clock high and checks the code, to catch a design that updates on the rising edge.

// File: rtl/gstep_pkg.sv
package gstep_pkg;
  typedef enum logic [1:0] {
    EV_RAISE = 2'd0,
    EV_LOWER = 2'd1,
    EV_RESET = 2'd2
  } ev_kind_t;
endpackage

// File: rtl/gstep_sync.sv
module gstep_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gstep_edge.sv
module gstep_edge
  import gstep_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_s,
  input  logic             sdat_s,
  input  logic [SEL_W-1:0] sel_s,
  output logic             evt_valid,
  output ev_kind_t         evt_kind,
  output logic [SEL_W-1:0] evt_sel
);
  logic sclk_q;
  logic dat_at_rise;
  logic rise, fall;

  assign rise = sclk_s & ~sclk_q;
  assign fall = ~sclk_s & sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q      <= 1'b0;
      dat_at_rise <= 1'b0;
      evt_valid   <= 1'b0;
      evt_kind    <= EV_RESET;
      evt_sel     <= '0;
    end else begin
      sclk_q    <= sclk_s;
      evt_valid <= fall;
      if (rise) dat_at_rise <= sdat_s;
      if (fall) begin
        evt_sel <= sel_s;
        if (sdat_s != dat_at_rise) evt_kind <= EV_RESET;
        else if (sdat_s)           evt_kind <= EV_RAISE;
        else                       evt_kind <= EV_LOWER;
      end
    end
  end
endmodule

// File: rtl/gstep_accum.sv
module gstep_accum
  import gstep_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_valid,
  input  ev_kind_t          evt_kind,
  input  logic [SEL_W-1:0]  evt_sel,
  output logic [CODE_W-1:0] code
);
  localparam int AMT_W = CODE_W + 1;
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic [AMT_W-1:0]  amount;
  logic [AMT_W-1:0]  sum;
  logic [CODE_W-1:0] next_code;

  assign amount = AMT_W'(1) << evt_sel;
  assign sum    = {1'b0, code} + amount;

  always_comb begin
    next_code = code;
    unique case (evt_kind)
      EV_RAISE: next_code = ({1'b0, code} < amount) ? '0 : CODE_W'({1'b0, code} - amount);
      EV_LOWER: next_code = (sum > AMT_W'(CODE_MAX)) ? CODE_MAX : sum[CODE_W-1:0];
      default:  next_code = CODE_MAX;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            code <= CODE_MAX;
    else if (evt_valid) code <= next_code;
  end
endmodule

// File: rtl/gain_stepper.sv
module gain_stepper
  import gstep_pkg::*;
#(
  parameter int CODE_W      = 6,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_clk_i,
  input  logic              step_dat_i,
  input  logic [SEL_W-1:0]  step_sel_i,
  output logic [CODE_W-1:0] gain_code_o
);
  localparam int BUS_W = SEL_W + 2;

  logic [BUS_W-1:0] pins_s;
  logic             evt_valid;
  ev_kind_t         evt_kind;
  logic [SEL_W-1:0] evt_sel;

  gstep_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({step_sel_i, step_dat_i, step_clk_i}),
    .q   (pins_s)
  );

  gstep_edge #(.SEL_W(SEL_W)) u_edge (
    .clk       (clk),
    .rst       (rst),
    .sclk_s    (pins_s[0]),
    .sdat_s    (pins_s[1]),
    .sel_s     (pins_s[BUS_W-1:2]),
    .evt_valid (evt_valid),
    .evt_kind  (evt_kind),
    .evt_sel   (evt_sel)
  );

  gstep_accum #(.CODE_W(CODE_W), .SEL_W(SEL_W)) u_accum (
    .clk       (clk),
    .rst       (rst),
    .evt_valid (evt_valid),
    .evt_kind  (evt_kind),
    .evt_sel   (evt_sel),
    .code      (gain_code_o)
  );
endmodule

// File: rtl/gain_stepper_chk.sv
module gain_stepper_chk
  import gstep_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int SEL_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] code,
  input logic              evt_valid,
  input ev_kind_t          evt_kind,
  input logic [SEL_W-1:0]  evt_sel
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  p_reset_value_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> code == CODE_MAX);

  p_raise_step_r2: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_kind == EV_RAISE) |=>
      (code == '0) || (int'($past(code)) - int'(code) == (1 << $past(evt_sel))));

  p_lower_step_r3: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_kind == EV_LOWER) |=>
      (code == CODE_MAX) || (int'(code) - int'($past(code)) == (1 << $past(evt_sel))));

  p_floor_r5: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_kind == EV_RAISE) |=> code <= $past(code));

  p_ceiling_r6: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_kind == EV_LOWER) |=> code >= $past(code));

  p_mismatch_reset_r7: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_kind == EV_RESET) |=> code == CODE_MAX);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !evt_valid |=> $stable(code));
endmodule

bind gain_stepper gain_stepper_chk #(.CODE_W(CODE_W), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .code      (gain_code_o),
  .evt_valid (evt_valid),
  .evt_kind  (evt_kind),
  .evt_sel   (evt_sel)
);

// File: tb/gain_stepper_test.sv
module gain_stepper_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk = 1'b0;
  logic       sdat = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [5:0] code;

  int checks = 0;
  int fails  = 0;
  int expv   = 63;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gain_stepper uut (
    .clk         (clk),
    .rst         (rst),
    .step_clk_i  (sclk),
    .step_dat_i  (sdat),
    .step_sel_i  (sel),
    .gain_code_o (code)
  );

  task automatic check(input string req, input int exp_code);
    checks++;
    if (int'(code) != exp_code) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, code, exp_code);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // full pulse; dat_rise at rising edge, dat_fall at falling edge
  task automatic pulse(input bit dat_rise, input bit dat_fall);
    sdat = dat_rise;
    idle(4);
    sclk = 1'b1;
    idle(6);
    sdat = dat_fall;
    idle(4);
    sclk = 1'b0;
    idle(6);
  endtask

  function automatic int step_of(input int s);
    return 1 << s;
  endfunction

  initial begin
    idle(4);
    check("R1", 63);
    rst = 1'b0;
    idle(6);
    check("R1", 63);

    for (int s = 0; s < 4; s++) begin
      sel = 2'(s);
      // raise gain down to the floor, then one extra step (R2, R4, R5)
      for (int k = 0; k < 64 / step_of(s) + 1; k++) begin
        pulse(1'b1, 1'b1);
        expv = (expv < step_of(s)) ? 0 : expv - step_of(s);
        check((k == 64 / step_of(s)) ? "R5" : "R2/R4", expv);
      end
      // lower gain up to the ceiling, then one extra step (R3, R4, R6)
      for (int k = 0; k < 64 / step_of(s) + 1; k++) begin
        pulse(1'b0, 1'b0);
        expv = (expv + step_of(s) > 63) ? 63 : expv + step_of(s);
        check((k == 64 / step_of(s)) ? "R6" : "R3/R4", expv);
      end
    end

    // select sampled at the falling edge (R4)
    sel = 2'd0;
    sdat = 1'b1;
    idle(4);
    sclk = 1'b1;
    idle(6);
    sel = 2'd3;
    idle(4);
    sclk = 1'b0;
    idle(6);
    expv = 55;
    check("R4", expv);

    // rising edge alone leaves the code, falling edge applies (R8)
    sel = 2'd1;
    sdat = 1'b1;
    idle(4);
    sclk = 1'b1;
    idle(20);
    check("R8", expv);
    sclk = 1'b0;
    idle(4);
    expv = 53;
    check("R8", expv);

    // mismatch reset, high then low (R7)
    pulse(1'b1, 1'b1);
    pulse(1'b1, 1'b1);
    expv = 49;
    check("R2", expv);
    pulse(1'b1, 1'b0);
    expv = 63;
    check("R7", expv);

    // mismatch reset, low then high, from a mid code (R7)
    sel = 2'd3;
    pulse(1'b1, 1'b1);
    pulse(1'b1, 1'b1);
    pulse(1'b1, 1'b1);
    expv = 39;
    check("R2", expv);
    pulse(1'b0, 1'b1);
    expv = 63;
    check("R7", expv);

    // reset from code 0 (R7)
    for (int k = 0; k < 8; k++) pulse(1'b1, 1'b1);
    check("R5", 0);
    pulse(1'b0, 1'b1);
    check("R7", 63);

    // synchronous reset mid-run (R1)
    pulse(1'b1, 1'b1);
    check("R2", 55);
    rst = 1'b1;
    idle(3);
    check("R1", 63);
    rst = 1'b0;
    idle(5);
    check("R1", 63);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule